// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns a device's address window registers into a single-cycle address decode. It watches the command enables and a bank of region registers: several ordinary regions followed by one expansion-ROM region in the highest slot. Each region has a byte size and a flag that says whether it lives in I/O space or memory space. For every region the block derives an aligned base and an inclusive limit. It then works out whether the region is currently live.

An incoming access (an address plus an I/O-or-memory flag) is matched against all live regions of the same space. The result is a hit flag, the index of the winning region and the byte offset of the access inside that region. The decode itself is combinational. The three results are captured in one output register stage, so a request presented before a rising edge is answered after that edge. The block only decodes; it never performs the access.

Top module: `bar_window_decoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs after that edge are `hit`=0, `region_idx`=0 and `offset`=0.
- R2: A region's base is its register value ANDed with the complement of (size - 1). Its limit is base + size - 1, in ADDR_W-bit arithmetic. An access hits when base <= address <= limit, and `offset` is address - base. The results appear one clock after the inputs are sampled.
- R3: A region whose `region_is_io` bit is 1 (not the ROM slot) is an I/O region. It is live only while `cmd_io_en` is 1. It matches only accesses with `acc_is_io`=1. Memory regions match only accesses with `acc_is_io`=0.
- R4: Memory regions and the ROM region are live only while `cmd_mem_en` is 1.
- R5: The ROM region is the highest index (NUM_REGIONS-1) and is always a memory region, whatever its `region_is_io` bit says. It is live only while bit 0 of its register value is 1.
- R6: A region whose aligned base is zero is never live.
- R7: A region whose limit is not greater than its base is never live. This covers wrap-around and a one-byte size.
- R8: An I/O region whose limit is 0x10000 or above is never live.
- R9: A region with size zero is never live.
- R10: When several live regions match the same access, the lowest index wins.
- R11: On a miss, `hit`=0, `region_idx`=0 and `offset`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_io_en | input | 1 | Command enable for I/O space decoding |
| cmd_mem_en | input | 1 | Command enable for memory space decoding |
| region_value | input | NUM_REGIONS*ADDR_W | Region register values, region i at bits [i*ADDR_W +: ADDR_W] |
| region_size | input | NUM_REGIONS*ADDR_W | Region byte sizes (zero or a power of two), same packing |
| region_is_io | input | NUM_REGIONS | Per-region space flag, 1 = I/O (ignored for the ROM slot) |
| acc_addr | input | ADDR_W | Access address |
| acc_is_io | input | 1 | Access space, 1 = I/O, 0 = memory |
| hit | output | 1 | Registered: the access falls in a live region |
| region_idx | output | IDX_W | Registered: index of the winning region |
| offset | output | ADDR_W | Registered: access address minus the winning base |

## Verification
The bench probes the first and last byte of a window and the byte past the limit. A design with an off-by-one limit would either lose the last byte or claim the next one. It places a region whose base masks to zero, a one-byte region and an I/O window that ends exactly at 0x0FFFF next to one that runs beyond it. A decoder that skips one of these validity rules would report hits where none belong. It also toggles each command enable and the ROM enable bit, feeds a memory access to an I/O window, and overlaps two windows so that a wrong priority order shows up as the wrong index. Randomised register and access patterns then run against the behavioural model, which is compared on every clock.

// File: rtl/bwd_pkg.sv
// Package: shared kinds for the base address window decoder.
// Assumes the ROM region always occupies the highest region index.
package bwd_pkg;

    typedef enum logic [1:0] {
        REGION_MEM = 2'd0,
        REGION_IO  = 2'd1,
        REGION_ROM = 2'd2
    } region_kind_e;

    // Classify a region slot from its position and its space flag.
    function automatic region_kind_e kind_of(input logic is_rom_slot, input logic is_io);
        if (is_rom_slot)
            return REGION_ROM;
        else if (is_io)
            return REGION_IO;
        else
            return REGION_MEM;
    endfunction

endpackage

// File: rtl/bwd_region_eval.sv
// Module: bwd_region_eval
// Derives one region's aligned base and inclusive limit, and decides whether
// the region is live under the command enables and the validity rules.
// Assumes size is zero or a power of two.
module bwd_region_eval
    import bwd_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int IO_SPACE_BITS = 16
) (
    input  region_kind_e        kind,
    input  logic [ADDR_W-1:0]   value,
    input  logic [ADDR_W-1:0]   size,
    input  logic                io_en,
    input  logic                mem_en,
    output logic                mapped,
    output logic [ADDR_W-1:0]   base,
    output logic [ADDR_W-1:0]   limit
);

    logic space_on;
    logic in_io_space;

    // Align the register value down to the size and form the inclusive limit.
    always_comb begin
        base  = value & ~(size - ADDR_W'(1));
        limit = base + size - ADDR_W'(1);
    end

    // Pick the enable that governs this kind of region.
    always_comb begin
        unique case (kind)
            REGION_IO:  space_on = io_en;
            REGION_ROM: space_on = mem_en & value[0];
            default:    space_on = mem_en;
        endcase
    end

    // I/O windows must end below the top of the I/O space.
    always_comb begin
        if (kind == REGION_IO)
            in_io_space = (limit[ADDR_W-1:IO_SPACE_BITS] == '0);
        else
            in_io_space = 1'b1;
    end

    // Combine the enable with the zero-size, zero-base and wrap rules.
    always_comb begin
        mapped = space_on && (size != '0) && (base != '0) && (limit > base) && in_io_space;
    end

endmodule

// File: rtl/bwd_region_match.sv
// Module: bwd_region_match
// Compares one access against one region window of the same address space.
// Assumes base and limit come from bwd_region_eval and are valid when mapped.
module bwd_region_match
    import bwd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  region_kind_e        kind,
    input  logic                mapped,
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W-1:0]   limit,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                acc_is_io,
    output logic                match
);

    logic same_space;

    // An I/O access may only hit I/O regions; memory accesses hit the rest.
    always_comb begin
        same_space = (acc_is_io == (kind == REGION_IO));
    end

    // Inclusive window compare, gated by liveness and space.
    always_comb begin
        match = mapped && same_space && (acc_addr >= base) && (acc_addr <= limit);
    end

endmodule

// File: rtl/bwd_prio_pick.sv
// Module: bwd_prio_pick
// Reduces a per-region match vector to a hit flag and the lowest set index.
// Assumes N >= 2.
module bwd_prio_pick #(
    parameter int N     = 7,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     match_vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest matching index is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i])
                idx = IDX_W'(i);
        end
        any = |match_vec;
    end

endmodule

// File: rtl/bar_window_decoder.sv
// Module: bar_window_decoder (top)
// Evaluates every region window, matches the access against all of them,
// picks the lowest-index hit and registers hit, index and offset once.
// Assumes the last region slot is the expansion ROM and sizes are powers of two.
module bar_window_decoder
    import bwd_pkg::*;
#(
    parameter int NUM_REGIONS   = 7,
    parameter int ADDR_W        = 32,
    parameter int IO_SPACE_BITS = 16,
    parameter int IDX_W         = $clog2(NUM_REGIONS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_io_en,
    input  logic                          cmd_mem_en,
    input  logic [NUM_REGIONS*ADDR_W-1:0] region_value,
    input  logic [NUM_REGIONS*ADDR_W-1:0] region_size,
    input  logic [NUM_REGIONS-1:0]        region_is_io,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic                          acc_is_io,
    output logic                          hit,
    output logic [IDX_W-1:0]              region_idx,
    output logic [ADDR_W-1:0]             offset
);

    localparam int ROM_SLOT = NUM_REGIONS - 1;

    logic [NUM_REGIONS-1:0] mapped_vec;
    logic [NUM_REGIONS-1:0] match_vec;
    logic [NUM_REGIONS-1:0] io_kind_vec;
    logic [ADDR_W-1:0]      base_arr  [NUM_REGIONS];
    logic [ADDR_W-1:0]      limit_arr [NUM_REGIONS];

    logic                   hit_d;
    logic [IDX_W-1:0]       idx_d;
    logic [ADDR_W-1:0]      offset_d;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        region_kind_e kind;

        // Fix the kind of this slot from its position and space flag.
        always_comb kind = kind_of(g == ROM_SLOT, region_is_io[g]);

        // Marks which slots are I/O windows, for the checks below.
        always_comb io_kind_vec[g] = (kind == REGION_IO);

        bwd_region_eval #(
            .ADDR_W        (ADDR_W),
            .IO_SPACE_BITS (IO_SPACE_BITS)
        ) u_eval (
            .kind   (kind),
            .value  (region_value[g*ADDR_W +: ADDR_W]),
            .size   (region_size[g*ADDR_W +: ADDR_W]),
            .io_en  (cmd_io_en),
            .mem_en (cmd_mem_en),
            .mapped (mapped_vec[g]),
            .base   (base_arr[g]),
            .limit  (limit_arr[g])
        );

        bwd_region_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .kind      (kind),
            .mapped    (mapped_vec[g]),
            .base      (base_arr[g]),
            .limit     (limit_arr[g]),
            .acc_addr  (acc_addr),
            .acc_is_io (acc_is_io),
            .match     (match_vec[g])
        );

        // R6 R7 R9
        live_window_sane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mapped_vec[g] |-> (base_arr[g] != '0) && (limit_arr[g] > base_arr[g]));

        // R8
        io_window_below_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mapped_vec[g] && io_kind_vec[g]) |-> (limit_arr[g] < (ADDR_W'(1) << IO_SPACE_BITS)));

        // R3
        io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (io_kind_vec[g] && !cmd_io_en) |-> !mapped_vec[g]);

        // R4
        mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!io_kind_vec[g] && !cmd_mem_en) |-> !mapped_vec[g]);
    end

    bwd_prio_pick #(
        .N     (NUM_REGIONS),
        .IDX_W (IDX_W)
    ) u_prio (
        .match_vec (match_vec),
        .any       (hit_d),
        .idx       (idx_d)
    );

    // Offset of the access inside the winning window, zero on a miss.
    always_comb begin
        offset_d = hit_d ? (acc_addr - base_arr[idx_d]) : '0;
    end

    // Single output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit        <= 1'b0;
            region_idx <= '0;
            offset     <= '0;
        end else begin
            hit        <= hit_d;
            region_idx <= idx_d;
            offset     <= offset_d;
        end
    end

    // R5
    rom_enable_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mapped_vec[ROM_SLOT] |-> region_value[ROM_SLOT*ADDR_W]);

    // R10
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_d |-> (match_vec[idx_d] &&
                   ((match_vec & ((NUM_REGIONS'(1) << idx_d) - NUM_REGIONS'(1))) == '0)));

    // R11
    miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (region_idx == '0) && (offset == '0));

endmodule

// File: tb/sim_bar_window_decoder.sv
module sim_bar_window_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NR         = 7;
    localparam int AW         = 32;
    localparam int IW         = 3;
    localparam int WATCHDOG   = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_io_en = 1'b0;
    logic          cmd_mem_en = 1'b0;
    logic [NR*AW-1:0] region_value;
    logic [NR*AW-1:0] region_size;
    logic [NR-1:0] region_is_io;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_is_io = 1'b0;
    logic          hit;
    logic [IW-1:0] region_idx;
    logic [AW-1:0] offset;

    logic [31:0] r_val  [NR];
    logic [31:0] r_size [NR];
    logic        r_io   [NR];

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack the bench's per-region arrays onto the flat ports.
    always_comb begin
        for (int i = 0; i < NR; i++) begin
            region_value[i*AW +: AW] = r_val[i];
            region_size[i*AW +: AW]  = r_size[i];
            region_is_io[i]          = r_io[i];
        end
    end

    bar_window_decoder #(.NUM_REGIONS(NR), .ADDR_W(AW)) u0 (
        .clk, .rst_n, .cmd_io_en, .cmd_mem_en, .region_value, .region_size,
        .region_is_io, .acc_addr, .acc_is_io, .hit, .region_idx, .offset
    );

    // Behavioural reference: walk the regions in order, first live match wins.
    task automatic model(output logic e_hit, output logic [IW-1:0] e_idx, output logic [AW-1:0] e_off);
        longint unsigned b, l, s, v, a;
        bit live, is_io;
        e_hit = 0; e_idx = 0; e_off = 0;
        a = longint'(acc_addr);
        for (int i = 0; i < NR; i++) begin
            s = longint'(r_size[i]);
            v = longint'(r_val[i]);
            is_io = (i != NR - 1) && r_io[i];
            if (s == 0) continue;
            b = v - (v % s);
            l = (b + s - 1) % 64'h1_0000_0000;
            live = (b != 0) && (l > b);
            if (is_io) live = live && cmd_io_en && (l < 64'h10000);
            else       live = live && cmd_mem_en;
            if (i == NR - 1) live = live && v[0];
            if (live && (acc_is_io == is_io) && a >= b && a <= l && !e_hit) begin
                e_hit = 1;
                e_idx = IW'(i);
                e_off = AW'(a - b);
            end
        end
    endtask

    // One clock: predict from the present inputs, then compare after the edge.
    task automatic step(input string tag);
        logic e_hit; logic [IW-1:0] e_idx; logic [AW-1:0] e_off;
        if (rst_n) model(e_hit, e_idx, e_off);
        else begin e_hit = 0; e_idx = 0; e_off = 0; end
        @(posedge clk);
        #1;
        checks++;
        if (hit !== e_hit || region_idx !== e_idx || offset !== e_off) begin
            failures++;
            $display("FAIL %s: actual hit=%0b idx=%0d off=%h expected hit=%0b idx=%0d off=%h",
                     tag, hit, region_idx, offset, e_hit, e_idx, e_off);
        end
    endtask

    // Directed expectation on top of the model comparison.
    task automatic expect_out(input string tag, input logic e_hit, input int e_idx, input logic [AW-1:0] e_off);
        checks++;
        if (hit !== e_hit || region_idx !== IW'(e_idx) || offset !== e_off) begin
            failures++;
            $display("FAIL %s: actual hit=%0b idx=%0d off=%h expected hit=%0b idx=%0d off=%h",
                     tag, hit, region_idx, offset, e_hit, e_idx, e_off);
        end
    endtask

    task automatic clear_regions();
        for (int i = 0; i < NR; i++) begin
            r_val[i] = '0; r_size[i] = '0; r_io[i] = 1'b0;
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input logic io, input string tag);
        acc_addr = a; acc_is_io = io;
        step(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_regions();
        r_val[0] = 32'h8000_1234; r_size[0] = 32'h1000;
        cmd_io_en = 1; cmd_mem_en = 1;
        acc_addr = 32'h8000_1ABC;
        #1;
        // R1: reset holds outputs at zero even with a hitting request
        rst_n = 0;
        step("R1"); step("R1");
        expect_out("R1", 0, 0, 0);
        rst_n = 1;

        // R2: alignment, boundaries and offset, one-cycle latency
        access(32'h8000_1ABC, 0, "R2"); expect_out("R2", 1, 0, 32'hABC);
        access(32'h8000_1000, 0, "R2"); expect_out("R2", 1, 0, 32'h0);
        access(32'h8000_1FFF, 0, "R2"); expect_out("R2", 1, 0, 32'hFFF);
        access(32'h8000_2000, 0, "R2"); expect_out("R11", 0, 0, 0);
        access(32'h8000_0FFF, 0, "R2"); expect_out("R11", 0, 0, 0);

        // R3: I/O windows, gating and space matching
        r_val[1] = 32'h0000_C001; r_size[1] = 32'h100; r_io[1] = 1;
        access(32'h0000_C010, 1, "R3"); expect_out("R3", 1, 1, 32'h10);
        access(32'h0000_C010, 0, "R3"); expect_out("R3", 0, 0, 0);
        access(32'h8000_1010, 1, "R3"); expect_out("R3", 0, 0, 0);
        cmd_io_en = 0;
        access(32'h0000_C010, 1, "R3"); expect_out("R3", 0, 0, 0);
        access(32'h8000_1010, 0, "R3"); expect_out("R3", 1, 0, 32'h10);
        cmd_io_en = 1;

        // R4: memory enable gates memory regions but not I/O
        cmd_mem_en = 0;
        access(32'h8000_1010, 0, "R4"); expect_out("R4", 0, 0, 0);
        access(32'h0000_C0FF, 1, "R4"); expect_out("R4", 1, 1, 32'hFF);
        cmd_mem_en = 1;

        // R5: ROM slot needs its enable bit, and is memory even if flagged I/O
        r_val[6] = 32'hE000_0000; r_size[6] = 32'h1_0000; r_io[6] = 1;
        access(32'hE000_0400, 0, "R5"); expect_out("R5", 0, 0, 0);
        r_val[6] = 32'hE000_0001;
        access(32'hE000_0400, 0, "R5"); expect_out("R5", 1, 6, 32'h400);
        access(32'hE000_0400, 1, "R5"); expect_out("R5", 0, 0, 0);
        cmd_mem_en = 0;
        access(32'hE000_0400, 0, "R5"); expect_out("R5", 0, 0, 0);
        cmd_mem_en = 1;

        // R6: base masking to zero
        r_val[2] = 32'h0000_0FFF; r_size[2] = 32'h1000;
        access(32'h0000_0010, 0, "R6"); expect_out("R6", 0, 0, 0);

        // R7: one-byte region has limit equal to base
        r_val[3] = 32'h0000_4000; r_size[3] = 32'h1;
        access(32'h0000_4000, 0, "R7"); expect_out("R7", 0, 0, 0);
        r_val[3] = 32'hFFFF_F000; r_size[3] = 32'h1000;
        access(32'hFFFF_FFFF, 0, "R7"); expect_out("R7", 1, 3, 32'hFFF);

        // R8: top of the I/O space
        r_val[4] = 32'h0000_FF00; r_size[4] = 32'h100; r_io[4] = 1;
        access(32'h0000_FFFF, 1, "R8"); expect_out("R8", 1, 4, 32'hFF);
        r_val[4] = 32'h0001_0000;
        access(32'h0001_0010, 1, "R8"); expect_out("R8", 0, 0, 0);

        // R9: zero size
        r_val[5] = 32'h4000_0000; r_size[5] = 32'h0;
        access(32'h4000_0000, 0, "R9"); expect_out("R9", 0, 0, 0);

        // R10: overlap, lowest index wins
        clear_regions();
        r_val[0] = 32'h9000_0000; r_size[0] = 32'h1000;
        r_val[2] = 32'h9000_0000; r_size[2] = 32'h1_0000;
        access(32'h9000_0800, 0, "R10"); expect_out("R10", 1, 0, 32'h800);
        access(32'h9000_1800, 0, "R10"); expect_out("R10", 1, 2, 32'h1800);

        // R11: complete miss
        access(32'h1234_5678, 0, "R11"); expect_out("R11", 0, 0, 0);

        // R2 R3 R10: randomised windows and accesses against the model
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < NR; i++) begin
                r_size[i] = ($urandom_range(0, 7) == 0) ? 32'h0 : (32'h1 << $urandom_range(0, 14));
                r_io[i]   = $urandom_range(0, 1);
                r_val[i]  = r_io[i] ? $urandom_range(0, 32'h1_1000) : ($urandom & 32'h000F_FFFF);
            end
            cmd_io_en  = ($urandom_range(0, 3) != 0);
            cmd_mem_en = ($urandom_range(0, 3) != 0);
            for (int k = 0; k < 20; k++) begin
                int sel;
                sel = $urandom_range(0, NR - 1);
                acc_addr  = (r_val[sel] & ~(r_size[sel] - 1)) + ($urandom & 32'h3FFF) - 32'h100;
                acc_is_io = $urandom_range(0, 1);
                step("R2/random");
            end
        end
        // R1: reset again in mid-run
        rst_n = 0;
        step("R1");
        rst_n = 1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule